// File: doc/BRIEF.md
# Blanked PWM Cycle Controller

This block drives the gate enable of a peak-current-mode switching converter for one switching cycle at a time. A strobe opens each cycle and raises the gate. The gate then drops when either of two external comparators reports that the sensed switch current is too high, or when the on-time reaches the maximum duty fraction of the period. Comparator reports that arrive during a short blanking window after turn-on are ignored, so the turn-on current spike cannot end the pulse early.

Alongside the gate, the block produces a digital current-limit code for an external comparator's DAC. Within each cycle the code climbs from a low floor toward a ceiling as the elapsed on-time grows toward a knee fraction of the period, and stays flat past the knee. A lower limit on the code starts at zero after reset, or after a global disable, and rises one step at a time. The code that goes out is the smaller of the two, so the first pulses after start-up are small.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: A `cyc_start` pulse sampled while `dis` is low and while floor(`period`*DMAX_PCT/100) is nonzero raises `gate` at that edge. The on-time count restarts from zero, including when `gate` is already high.
- R2: A trip on `ilim_trip` or `fb_trip` has no effect on `gate` while fewer than BLANK_CYC clocks of on-time have elapsed. The on-time count is 0 at the launching edge and grows by one per clock.
- R3: A trip sampled with the gate high, once the blanking window is over, clears `gate` at that edge. `gate` then stays low until the next accepted start.
- R4: `gate` stays high for at most floor(`period`*DMAX_PCT/100) clocks, with `period` sampled at the start. A start is ignored when that value is zero.
- R5: `fb_trip` ends the pulse exactly as `ilim_trip` does.
- R6: While `gate` is high with k clocks of on-time elapsed, the sawtooth value is min(LIM_HI, LIM_LO + floor(k*(LIM_HI-LIM_LO)/K)), where K = floor(`period`*KNEE_PCT/100) and K >= LIM_HI-LIM_LO. While `gate` is low, the sawtooth value is LIM_LO.
- R7: The soft-start limit equals min(LIM_HI, floor(n/SS_STEP)), where n counts the edges since reset release or since the last edge at which `dis` was high. It is 0 during reset.
- R8: `ilim_code` equals the smaller of the sawtooth value and the soft-start limit.
- R9: `dis` sampled high clears `gate` at that edge, resets the soft-start limit to 0 and blocks any start sampled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe that opens a switching cycle |
| period | input | CNT_W | Switching period in clocks, sampled at the start |
| ilim_trip | input | 1 | Current-limit comparator output (sense above `ilim_code`) |
| fb_trip | input | 1 | Feedback comparator output (sense above scaled feedback) |
| dis | input | 1 | Global disable |
| gate | output | 1 | Gate-drive enable |
| ilim_code | output | CODE_W | Current-limit threshold code |

## Verification
The bench uses a 12-bit period, a blanking window of 4 clocks, a code range of 20 to 40 and a soft-start step of 8 clocks. With these values the soft-start limit cuts into the sawtooth for the first few hundred clocks and then releases it, so both sides of the minimum are seen. Periods of 40 to 200 clocks make the 4-clock blanking window, the knee and the 70% duty limit land at distinct on-times. A period of 1 gives a zero maximum on-time, which exercises the ignored-start case.

// File: rtl/pwm_cyc_pkg.sv
package pwm_cyc_pkg;

    // Percent denominator for duty fractions
    localparam int unsigned PCT_DEN = 100;

    // Reason the running pulse ends at this edge
    typedef enum logic [1:0] {
        END_NONE,
        END_TRIP,
        END_DMAX,
        END_OFF
    } gate_end_e;

endpackage

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
    import pwm_cyc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int BLANK_CYC = 90,
    parameter int DMAX_PCT  = 70,
    parameter int KNEE_PCT  = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [CNT_W-1:0] period,
    input  logic             ilim_trip,
    input  logic             fb_trip,
    input  logic             dis,
    output logic             gate,
    output logic             launch,
    output logic             hold,
    output logic [CNT_W-1:0] knee
);

    localparam int PROD_W = CNT_W + 8;
    localparam logic [CNT_W-1:0] BLANK_LIM = CNT_W'(BLANK_CYC);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] ton;
        logic [CNT_W-1:0] tmax;
        logic [CNT_W-1:0] knee;
    } gate_st_t;

    gate_st_t         st_d, st_q;
    logic [PROD_W-1:0] dmax_prod, knee_prod;
    logic [CNT_W-1:0]  tmax_new, knee_new;
    logic              blanked, trip_any, at_max, launch_w;
    gate_end_e         end_why;

    always_comb begin
        dmax_prod = PROD_W'(period) * PROD_W'(DMAX_PCT);
        knee_prod = PROD_W'(period) * PROD_W'(KNEE_PCT);
        tmax_new  = CNT_W'(dmax_prod / PROD_W'(PCT_DEN));
        knee_new  = CNT_W'(knee_prod / PROD_W'(PCT_DEN));

        launch_w  = cyc_start && !dis && (tmax_new != '0);
        blanked   = st_q.ton < BLANK_LIM;
        trip_any  = ilim_trip || fb_trip;
        at_max    = ({1'b0, st_q.ton} + (CNT_W+1)'(1)) >= {1'b0, st_q.tmax};

        if (dis)                      end_why = END_OFF;
        else if (trip_any && !blanked) end_why = END_TRIP;
        else if (at_max)              end_why = END_DMAX;
        else                          end_why = END_NONE;

        st_d = st_q;
        if (dis) begin
            st_d.on = 1'b0;
        end else if (launch_w) begin
            st_d.on   = 1'b1;
            st_d.ton  = '0;
            st_d.tmax = tmax_new;
            st_d.knee = knee_new;
        end else if (st_q.on) begin
            if (end_why != END_NONE) begin
                st_d.on = 1'b0;
            end else begin
                st_d.ton = st_q.ton + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate   = st_q.on;
    assign launch = launch_w;
    assign hold   = st_q.on && st_d.on && !launch_w;
    assign knee   = st_q.knee;

    AST_GATE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch_w |=> (gate && st_q.ton == '0));                                   // R1
    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && st_q.ton < BLANK_LIM && !dis && !at_max) |=> gate);              // R2
    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !blanked && (ilim_trip || fb_trip) && !launch_w) |=> !gate);     // R3
    AST_STAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !launch_w) |=> !gate);                                          // R3
    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (st_q.ton < st_q.tmax));                                         // R4
    AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !gate);                                                           // R9

endmodule

// File: rtl/pwm_saw_lim.sv
module pwm_saw_lim #(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 8,
    parameter int LIM_LO = 125,
    parameter int LIM_HI = 159
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              hold,
    input  logic [CNT_W-1:0]  knee,
    output logic [CODE_W-1:0] saw
);

    localparam int ACC_W = CNT_W + 1;
    localparam int SPAN  = LIM_HI - LIM_LO;
    localparam logic [CODE_W-1:0] CODE_LO = CODE_W'(LIM_LO);
    localparam logic [CODE_W-1:0] CODE_HI = CODE_W'(LIM_HI);

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CODE_W-1:0] code;
    } saw_st_t;

    saw_st_t          st_d, st_q;
    logic [ACC_W-1:0] sum, knee_e;

    always_comb begin
        knee_e = (knee == '0) ? ACC_W'(1) : {1'b0, knee};
        sum    = st_q.acc + ACC_W'(SPAN);
        st_d   = st_q;
        if (launch) begin
            st_d.acc  = '0;
            st_d.code = CODE_LO;
        end else if (hold) begin
            if (sum >= knee_e) begin
                st_d.acc  = sum - knee_e;
                st_d.code = (st_q.code >= CODE_HI) ? CODE_HI : st_q.code + CODE_W'(1);
            end else begin
                st_d.acc  = sum;
            end
        end else begin
            st_d.acc  = '0;
            st_d.code = CODE_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc  <= '0;
            st_q.code <= CODE_LO;
        end else begin
            st_q <= st_d;
        end
    end

    assign saw = st_q.code;

    AST_SAW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (saw >= CODE_LO && saw <= CODE_HI));                                      // R6
    AST_SAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !hold) |=> (saw == CODE_LO));                                 // R6
    AST_SAW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (saw == $past(saw) || saw == $past(saw) + CODE_W'(1)));          // R6

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
    parameter int CODE_W  = 8,
    parameter int LIM_HI  = 159,
    parameter int SS_STEP = 15723
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis,
    output logic [CODE_W-1:0] ss
);

    localparam int DIV_W = $clog2(SS_STEP + 1);
    localparam logic [DIV_W-1:0]  DIV_END = DIV_W'(SS_STEP - 1);
    localparam logic [CODE_W-1:0] CAP     = CODE_W'(LIM_HI);

    typedef struct packed {
        logic [CODE_W-1:0] lvl;
        logic [DIV_W-1:0]  div;
    } ss_st_t;

    ss_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dis) begin
            st_d = '0;
        end else if (st_q.lvl != CAP) begin
            if (st_q.div == DIV_END) begin
                st_d.div = '0;
                st_d.lvl = st_q.lvl + CODE_W'(1);
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ss = st_q.lvl;

    AST_SS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        ss <= CAP);                                                               // R7
    AST_SS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !dis |=> (ss >= $past(ss)));                                              // R7
    AST_SS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (ss == '0));                                                      // R9

endmodule

// File: rtl/pwm_cycle_ctrl.sv
module pwm_cycle_ctrl #(
    parameter int CNT_W     = 16,
    parameter int CODE_W    = 8,
    parameter int BLANK_CYC = 90,
    parameter int DMAX_PCT  = 70,
    parameter int KNEE_PCT  = 51,
    parameter int LIM_LO    = 125,
    parameter int LIM_HI    = 159,
    parameter int SS_STEP   = 15723
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [CNT_W-1:0]  period,
    input  logic              ilim_trip,
    input  logic              fb_trip,
    input  logic              dis,
    output logic              gate,
    output logic [CODE_W-1:0] ilim_code
);

    logic              launch, hold;
    logic [CNT_W-1:0]  knee;
    logic [CODE_W-1:0] saw, ss;

    pwm_gate_seq #(
        .CNT_W    (CNT_W),
        .BLANK_CYC(BLANK_CYC),
        .DMAX_PCT (DMAX_PCT),
        .KNEE_PCT (KNEE_PCT)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_start(cyc_start),
        .period   (period),
        .ilim_trip(ilim_trip),
        .fb_trip  (fb_trip),
        .dis      (dis),
        .gate     (gate),
        .launch   (launch),
        .hold     (hold),
        .knee     (knee)
    );

    pwm_saw_lim #(
        .CNT_W (CNT_W),
        .CODE_W(CODE_W),
        .LIM_LO(LIM_LO),
        .LIM_HI(LIM_HI)
    ) u_saw (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .hold  (hold),
        .knee  (knee),
        .saw   (saw)
    );

    pwm_softstart #(
        .CODE_W (CODE_W),
        .LIM_HI (LIM_HI),
        .SS_STEP(SS_STEP)
    ) u_ss (
        .clk  (clk),
        .rst_n(rst_n),
        .dis  (dis),
        .ss   (ss)
    );

    // Effective limit: the lower of the in-cycle ramp and the start-up cap
    assign ilim_code = (saw < ss) ? saw : ss;

    AST_CODE_UNDER_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_code <= ss && ilim_code <= saw));                                   // R8

endmodule

// File: tb/tb_pwm_cycle_ctrl.sv
module tb_pwm_cycle_ctrl;

    localparam int CNT_W     = 12;
    localparam int CODE_W    = 6;
    localparam int BLANK_CYC = 4;
    localparam int DMAX_PCT  = 70;
    localparam int KNEE_PCT  = 51;
    localparam int LIM_LO    = 20;
    localparam int LIM_HI    = 40;
    localparam int SS_STEP   = 8;
    localparam int SPAN      = LIM_HI - LIM_LO;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_start = 1'b0;
    logic [CNT_W-1:0]  period = '0;
    logic              ilim_trip = 1'b0;
    logic              fb_trip = 1'b0;
    logic              dis = 1'b0;
    logic              gate;
    logic [CODE_W-1:0] ilim_code;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    pwm_cycle_ctrl #(
        .CNT_W    (CNT_W),
        .CODE_W   (CODE_W),
        .BLANK_CYC(BLANK_CYC),
        .DMAX_PCT (DMAX_PCT),
        .KNEE_PCT (KNEE_PCT),
        .LIM_LO   (LIM_LO),
        .LIM_HI   (LIM_HI),
        .SS_STEP  (SS_STEP)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_start(cyc_start),
        .period   (period),
        .ilim_trip(ilim_trip),
        .fb_trip  (fb_trip),
        .dis      (dis),
        .gate     (gate),
        .ilim_code(ilim_code)
    );

    // Behavioural reference, updated on every rising edge
    int    m_on = 0, m_ton = 0, m_tmax = 0, m_knee = 1, m_n = 0;
    string m_tag = "R7";

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_ton = 0; m_n = 0; m_tag = "R7";
        end else if (dis) begin
            m_on = 0; m_n = 0; m_tag = "R9";
        end else begin
            int tm;
            m_n++;
            tm = (int'(period) * DMAX_PCT) / 100;
            if (cyc_start && tm != 0) begin
                m_on = 1; m_ton = 0; m_tmax = tm;
                m_knee = (int'(period) * KNEE_PCT) / 100;
                if (m_knee == 0) m_knee = 1;
                m_tag = "R1";
            end else if (m_on != 0) begin
                if ((ilim_trip || fb_trip) && m_ton >= BLANK_CYC) begin
                    m_on = 0;
                    m_tag = ilim_trip ? "R3" : "R5";
                end else if (m_ton + 1 >= m_tmax) begin
                    m_on = 0; m_tag = "R4";
                end else begin
                    m_tag = ((ilim_trip || fb_trip) && m_ton < BLANK_CYC) ? "R2" : "R4";
                    m_ton++;
                end
            end else begin
                m_tag = cyc_start ? "R4" : "R3";
            end
        end
    end

    // Compare on the falling edge, away from the sampling edge
    always @(negedge clk) begin
        if (!done) begin
            int e_saw, e_ss, e_code;
            e_saw  = (m_on != 0) ? imin(LIM_HI, LIM_LO + (m_ton * SPAN) / m_knee) : LIM_LO;
            e_ss   = imin(LIM_HI, m_n / SS_STEP);
            e_code = imin(e_saw, e_ss);
            n_checks++;
            if (gate !== (m_on != 0)) begin
                n_fails++;
                $display("FAIL %s gate actual=%0b expected=%0b at %0t", m_tag, gate, m_on, $time);
            end
            n_checks++;
            if (int'(ilim_code) != e_code) begin
                n_fails++;
                if (e_ss < e_saw)
                    $display("FAIL R8 (soft-start R7) ilim_code actual=%0d expected=%0d at %0t",
                             ilim_code, e_code, $time);
                else
                    $display("FAIL R8 (sawtooth R6) ilim_code actual=%0d expected=%0d at %0t",
                             ilim_code, e_code, $time);
            end
        end
    end

    // mode: 0 quiet, 1 random ilim_trip, 2 random fb_trip (R5), 3 both held high
    task automatic go(input int per, input int gap, input int mode, input int ncyc);
        for (int c = 0; c < ncyc; c++) begin
            for (int k = 0; k < gap; k++) begin
                cyc_start = (k == 0);
                period    = CNT_W'(per);
                ilim_trip = (mode == 3) || (mode == 1 && $urandom_range(0, 15) == 0);
                fb_trip   = (mode == 3) || (mode == 2 && $urandom_range(0, 15) == 0);
                @(negedge clk);
            end
        end
        cyc_start = 1'b0;
        ilim_trip = 1'b0;
        fb_trip   = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);          // reset state checked meanwhile (R7)
        rst_n = 1'b1;
        go(100, 100, 0, 6);                 // R4 max duty, R7 ramp limiting R6
        go(100, 100, 0, 4);                 // R6 full sawtooth after soft-start
        go(60, 60, 1, 30);                  // R3 current-limit trips, R2 blanking
        go(40, 40, 2, 30);                  // R5 feedback trips
        go(100, 100, 3, 5);                 // R2 trips held through blanking
        go(100, 30, 0, 8);                  // R1 restart while gate high
        go(1, 10, 0, 5);                    // R4 zero max on-time ignored
        go(100, 100, 0, 1);
        // R9: disable in mid-pulse, starts while disabled
        cyc_start = 1'b1; period = CNT_W'(120);
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (30) @(negedge clk);
        dis = 1'b1;
        go(100, 7, 1, 3);
        dis = 1'b0;
        go(100, 100, 1, 6);                 // R7 ramp again after disable
        for (int i = 0; i < 60; i++) begin
            int p;
            p = $urandom_range(40, 200);
            if ($urandom_range(0, 9) == 0) dis = 1'b1;
            go(p, $urandom_range(20, p), $urandom_range(0, 2), 1);
            dis = 1'b0;
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule